// File: doc/BRIEF.md
# Bus Target with Burst Data Phases

This block is the slave side of a 32-bit multiplexed address/data PCI bus. It watches for the start of each transaction and takes the address and command from the first clock of FRAME#. It claims transactions that fall inside one of two small windows, one in memory space and one in I/O space. It then moves one 32-bit word per completed data phase between the bus and a plain register port on the back end. Bursts of any length are supported. Either side may insert wait states: the master by holding IRDY# high, and the back end by holding `bk_ready` low.

The back-end port follows valid/ready rules. `bk_valid` rises in a data phase once the master has asserted IRDY#, and it stays high until `bk_ready` is seen. A clock with both signals high is exactly one bus transfer. For writes, `bk_wdata` and `bk_be` are valid in that clock. For reads, the back end must present `bk_rdata` for `bk_addr` combinationally in any clock where `bk_ready` is high. `bk_ready` may be high or low at any time; it is ignored outside a handshake. The target never asserts STOP#, so every burst ends at the master's request or by master abort.

Top module: `pci_tgt_core`

## Requirements
- R1: After reset, `devsel_n`, `trdy_n` and `stop_n` are high, and `ad_oe`, `par_oe` and `bk_valid` are low.
- R2: An address phase is the first clock in which `frame_n` is sampled low after being high. The target claims the transaction in two cases: memory command 0110 or 0111 with AD inside the memory window, or I/O command 0010 or 0011 with AD inside the I/O window. Each window is 2^ADDR_W words, aligned, with base MEM_BASE and IO_BASE. A claimed transaction has `devsel_n` low from the next clock until its last transfer.
- R3: A word moves only on a clock where `irdy_n` and `trdy_n` are both sampled low. `trdy_n` is low exactly in a data clock with `bk_ready` high. Any other clock is a wait.
- R4: The first word offset is AD[ADDR_W+1:2] of the address phase. The offset increases by one word (4 bytes) per transfer and wraps inside the window.
- R5: For writes, byte lane i (bits 8i+7:8i) is written only when C/BE# bit i is low in that data clock. `bk_be` is the inverse of C/BE#.
- R6: The commands 1100 and 1110 behave exactly as a memory read (0110). The command 1111 behaves exactly as a memory write (0111).
- R7: Some transactions are never claimed: the codes 0100, 0101, 1000 and 1001, the config codes 1010 and 1011, and the codes 0000, 0001 and 1101. A miss of both windows is also not claimed. An unclaimed transaction never asserts `devsel_n` or `bk_valid`, so the master ends by master abort.
- R8: In a read, the clock after the address phase is a turnaround clock: `ad_oe` is low and `trdy_n` high. In the data clocks after it, `ad_oe` is high and `ad_out` carries `bk_rdata`.
- R9: `par_oe` is high in the clock after each clock with `ad_oe` high. In that clock, `par` is the XOR of `ad_out` and `cbe_n` from the previous clock, so AD, C/BE# and PAR together hold an even number of ones.
- R10: The last data phase is the transfer in which `frame_n` is high. In the clock after it, `devsel_n` and `trdy_n` are high.
- R11: `stop_n` is never low.
- R12: `bk_valid` is high exactly in data clocks with `irdy_n` low. A back-end handshake occurs exactly on a bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Transaction framing from the master, active low |
| irdy_n | input | 1 | Master ready, active low |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| ad_in | input | 32 | Address/data from the bus |
| ad_out | output | 32 | Read data toward the bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| par | output | 1 | Even parity over the previous clock's AD and C/BE# |
| par_oe | output | 1 | Drive enable for `par` |
| devsel_n | output | 1 | Transaction claimed, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, held high |
| bk_valid | output | 1 | Back-end access request |
| bk_ready | input | 1 | Back-end accepts or supplies the word |
| bk_we | output | 1 | Access is a write |
| bk_addr | output | ADDR_W | Word offset inside the window |
| bk_be | output | 4 | Byte enables, active high |
| bk_wdata | output | 32 | Write data |
| bk_rdata | input | 32 | Read data for `bk_addr` |

## Verification
The assertions watch local cycle rules on every clock:
- TRDY# never shows without DEVSEL#, and both drop after the final transfer.
- The word offset steps by one after each non-final transfer.
- A read opens with its turnaround clock, and a miss leaves DEVSEL# high.
- Parity follows the AD drive by one clock, and a pending back-end request holds.

The data itself can only be shown by the bench scenarios:
- read-back of written words, byte-lane merging and window wrap;
- the aliased command codes;
- the absence of any write during an unclaimed command.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_TURN, PH_DATA} phase_e;
  typedef enum logic [1:0] {SP_NONE, SP_MEM, SP_IO} space_e;

  typedef struct packed {
    space_e space;
    logic   rd;
  } cmd_info_t;

  // Command code to address space and direction; aliases fold onto plain read/write.
  function automatic cmd_info_t classify(input logic [3:0] code);
    cmd_info_t r;
    r.space = SP_NONE;
    r.rd    = 1'b0;
    case (code)
      4'b0010: begin r.space = SP_IO;  r.rd = 1'b1; end
      4'b0011: begin r.space = SP_IO;  r.rd = 1'b0; end
      4'b0110,
      4'b1100,
      4'b1110: begin r.space = SP_MEM; r.rd = 1'b1; end
      4'b0111,
      4'b1111: begin r.space = SP_MEM; r.rd = 1'b0; end
      default: begin r.space = SP_NONE; r.rd = 1'b0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000
) (
  input  logic [31:2]       ad_hi,
  input  logic [3:0]        code,
  output logic              hit,
  output logic              rd,
  output logic [ADDR_W-1:0] word
);
  localparam int TAG_LO = ADDR_W + 2;

  cmd_info_t info;
  logic      mem_match;
  logic      io_match;

  always_comb begin
    info      = classify(code);
    mem_match = (ad_hi[31:TAG_LO] == MEM_BASE[31:TAG_LO]);
    io_match  = (ad_hi[31:TAG_LO] == IO_BASE[31:TAG_LO]);
    hit       = ((info.space == SP_MEM) && mem_match) ||
                ((info.space == SP_IO) && io_match);
    rd        = info.rd;
    word      = ad_hi[TAG_LO-1:2];
  end

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
  import pci_tgt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              hit,
  input  logic              rd_cmd,
  input  logic [ADDR_W-1:0] start_word,
  input  logic              bk_ready,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              drive,
  output logic              bk_valid,
  output logic              is_rd,
  output logic [ADDR_W-1:0] word
);
  phase_e phase;
  logic   frame_q;
  logic   start;
  logic   xfer;

  assign start    = (phase == PH_IDLE) && !frame_n && frame_q;
  assign xfer     = (phase == PH_DATA) && !irdy_n && bk_ready;
  assign devsel_n = (phase == PH_IDLE);
  assign trdy_n   = !((phase == PH_DATA) && bk_ready);
  assign bk_valid = (phase == PH_DATA) && !irdy_n;
  assign drive    = (phase == PH_DATA) && is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      frame_q <= 1'b1;
      is_rd   <= 1'b0;
      word    <= '0;
    end else begin
      frame_q <= frame_n;
      case (phase)
        PH_IDLE: if (start && hit) begin
          is_rd <= rd_cmd;
          word  <= start_word;
          phase <= rd_cmd ? PH_TURN : PH_DATA;
        end
        PH_TURN: phase <= PH_DATA;
        PH_DATA: if (xfer) begin
          word <= word + 1'b1;
          if (frame_n) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3
  trdy_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  // R10
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_n) |=> (devsel_n && trdy_n));

  // R4
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !frame_n) |=> (word == $past(word) + 1'b1));

  // R8
  turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hit && rd_cmd) |=> (!drive && trdy_n && !devsel_n));

  // R7
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hit) |=> devsel_n);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_valid && !bk_ready) |=> bk_valid);

endmodule

// File: rtl/pci_tgt_parity.sv
module pci_tgt_parity (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ad_oe,
  input  logic [31:0] ad_out,
  input  logic [3:0]  cbe_n,
  output logic        par,
  output logic        par_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par    <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par    <= ^{ad_out, cbe_n};
      par_oe <= ad_oe;
    end
  end

  // R9
  par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |=> par_oe);

endmodule

// File: rtl/pci_tgt_core.sv
module pci_tgt_core
  import pci_tgt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [3:0]        cbe_n,
  input  logic [31:0]       ad_in,
  output logic [31:0]       ad_out,
  output logic              ad_oe,
  output logic              par,
  output logic              par_oe,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              bk_valid,
  input  logic              bk_ready,
  output logic              bk_we,
  output logic [ADDR_W-1:0] bk_addr,
  output logic [3:0]        bk_be,
  output logic [31:0]       bk_wdata,
  input  logic [31:0]       bk_rdata
);
  logic              dec_hit;
  logic              dec_rd;
  logic [ADDR_W-1:0] dec_word;
  logic              rd_q;

  pci_tgt_decode #(.ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)) u_dec (
    .ad_hi (ad_in[31:2]),
    .code  (cbe_n),
    .hit   (dec_hit),
    .rd    (dec_rd),
    .word  (dec_word)
  );

  pci_tgt_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .hit        (dec_hit),
    .rd_cmd     (dec_rd),
    .start_word (dec_word),
    .bk_ready   (bk_ready),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .drive      (ad_oe),
    .bk_valid   (bk_valid),
    .is_rd      (rd_q),
    .word       (bk_addr)
  );

  pci_tgt_parity u_par (
    .clk    (clk),
    .rst_n  (rst_n),
    .ad_oe  (ad_oe),
    .ad_out (ad_out),
    .cbe_n  (cbe_n),
    .par    (par),
    .par_oe (par_oe)
  );

  assign ad_out   = bk_rdata;
  assign bk_we    = !rd_q;
  assign bk_be    = ~cbe_n;
  assign bk_wdata = ad_in;
  assign stop_n   = 1'b1;

endmodule

// File: tb/sim_pci_tgt_core.sv
`timescale 1ns/1ps
module sim_pci_tgt_core;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, par, par_oe, devsel_n, trdy_n, stop_n;
  logic        bk_valid, bk_ready = 1'b1, bk_we;
  logic [3:0]  bk_addr;
  logic [3:0]  bk_be;
  logic [31:0] bk_wdata, bk_rdata;

  pci_tgt_core u0 (.*);

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // back-end stub register file
  logic [31:0] bmem [16];
  assign bk_rdata = bmem[bk_addr];
  always @(posedge clk)
    if (bk_valid && bk_ready && bk_we)
      for (int b = 0; b < 4; b++)
        if (bk_be[b]) bmem[bk_addr][8*b +: 8] <= bk_wdata[8*b +: 8];

  // back-end ready pattern
  logic [7:0] rdy_pat = 8'hFF;
  int rc = 0;
  always @(posedge clk) begin
    #1;
    rc++;
    bk_ready = rdy_pat[rc % 8];
  end

  // reference memory image
  logic [31:0] exp_mem [16];

  function automatic bit mhit(input logic [31:0] a, input logic [3:0] c);
    bit m  = (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
    bit io = (c == 4'h2) || (c == 4'h3);
    return (m && ((a & ~32'h3F) == 32'h8000_0000)) ||
           (io && ((a & ~32'h3F) == 32'h0000_1000));
  endfunction

  function automatic bit mrd(input logic [3:0] c);
    return (c == 4'h2) || (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
  endfunction

  // cycle reference model: 0 idle, 1 turnaround, 2 data
  int ms = 0;
  bit m_rd = 0, fq = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; fq = 1;
    end else begin
      case (ms)
        0: if (!frame_n && fq && mhit(ad_in, cbe_n)) begin
             m_rd = mrd(cbe_n);
             ms = m_rd ? 1 : 2;
           end
        1: ms = 2;
        default: if (!irdy_n && bk_ready && frame_n) ms = 0;
      endcase
      fq = frame_n;
    end
  end

  bit p_oe = 0, p_par = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(devsel_n == (ms == 0), "R2/R10", "devsel_n", devsel_n, (ms == 0));
      chk(trdy_n == !(ms == 2 && bk_ready), "R3", "trdy_n", trdy_n, !(ms == 2 && bk_ready));
      chk(ad_oe == (ms == 2 && m_rd), "R8", "ad_oe", ad_oe, (ms == 2 && m_rd));
      chk(bk_valid == (ms == 2 && !irdy_n), "R12", "bk_valid", bk_valid, (ms == 2 && !irdy_n));
      chk(stop_n == 1'b1, "R11", "stop_n", stop_n, 1);
      if (p_oe) begin
        chk(par_oe == 1'b1, "R9", "par_oe", par_oe, 1);
        chk(par == p_par, "R9", "par", par, p_par);
      end else begin
        chk(par_oe == 1'b0, "R9", "par_oe idle", par_oe, 0);
      end
      p_oe  = ad_oe;
      p_par = ^{ad_out, cbe_n};
    end
  end

  // master
  logic [31:0] wbuf [8];
  logic [31:0] rbuf [8];
  int nx;
  bit aborted;

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                     input logic [3:0] be_n, input logic [7:0] iwait);
    bit wr = !mrd(cmd);
    bit holding = 0;
    int cyc = 0;
    int w0 = (addr >> 2) & 15;
    nx = 0; aborted = 0;
    @(posedge clk); #1;
    frame_n = 1'b0; ad_in = addr; cbe_n = cmd; irdy_n = 1'b1;
    while (nx < n) begin
      @(posedge clk); #1;
      cbe_n = be_n;
      ad_in = wr ? wbuf[nx] : 32'h0;
      irdy_n = holding ? 1'b0 : iwait[cyc % 8];
      frame_n = (nx == n - 1 && !irdy_n) ? 1'b1 : 1'b0;
      cyc++;
      @(negedge clk);
      if (!irdy_n && !trdy_n) begin
        if (!wr) rbuf[nx] = ad_out;
        else
          for (int b = 0; b < 4; b++)
            if (!be_n[b]) exp_mem[(w0 + nx) % 16][8*b +: 8] = wbuf[nx][8*b +: 8];
        nx++;
        holding = 0;
      end else if (!irdy_n) holding = 1;
      if (devsel_n && cyc >= 5) begin
        aborted = 1;
        break;
      end
    end
    @(posedge clk); #1;
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
  endtask

  task automatic rd_check(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                          input logic [7:0] iwait, input string req);
    int w0 = (addr >> 2) & 15;
    txn(cmd, addr, n, 4'h0, iwait);
    chk(!aborted, req, "read claimed", aborted, 0);
    for (int i = 0; i < n; i++)
      chk(rbuf[i] === exp_mem[(w0 + i) % 16], req, "read data", rbuf[i], exp_mem[(w0 + i) % 16]);
  endtask

  task automatic full_compare(input string req);
    rd_check(4'h6, 32'h8000_0000, 8, 8'h00, req);
    rd_check(4'h6, 32'h8000_0020, 8, 8'h00, req);
  endtask

  bit done = 0;
  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      bmem[i]    = 32'hA500_0000 ^ (i * 32'h0101_0101);
      exp_mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(devsel_n && trdy_n && stop_n, "R1", "ctl idle", {devsel_n, trdy_n, stop_n}, 3'b111);
    chk(!ad_oe && !par_oe && !bk_valid, "R1", "oe idle", {ad_oe, par_oe, bk_valid}, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R2 single memory write then read
    wbuf[0] = 32'h1234_5678;
    txn(4'h7, 32'h8000_0008, 1, 4'h0, 8'h00);
    chk(!aborted, "R2", "write claimed", aborted, 0);
    rd_check(4'h6, 32'h8000_0008, 1, 8'h00, "R2");

    // R3 R4 burst with waits from both sides
    rdy_pat = 8'b1011_0110;
    for (int i = 0; i < 6; i++) wbuf[i] = 32'hC0DE_0000 + i * 32'h111;
    txn(4'h7, 32'h8000_0010, 6, 4'h0, 8'b0100_1010);
    chk(nx == 6, "R3", "burst write count", nx, 6);
    rd_check(4'h6, 32'h8000_0010, 6, 8'b0010_0101, "R3");

    // R4 wrap inside window
    rdy_pat = 8'hFF;
    for (int i = 0; i < 4; i++) wbuf[i] = 32'hBEEF_0000 + i;
    txn(4'h7, 32'h8000_0038, 4, 4'h0, 8'h00);
    rd_check(4'h6, 32'h8000_0038, 4, 8'h00, "R4");

    // R5 byte enables: bytes 0 and 2 only (C/BE# = 1010)
    wbuf[0] = 32'h1122_3344;
    txn(4'h7, 32'h8000_0004, 1, 4'b1010, 8'h00);
    rd_check(4'h6, 32'h8000_0004, 1, 8'h00, "R5");
    chk(exp_mem[1][15:8] == bmem[1][15:8], "R5", "masked lane", bmem[1][15:8], exp_mem[1][15:8]);

    // R2 I/O space
    rdy_pat = 8'b1101_1011;
    wbuf[0] = 32'h0F0F_1E1E; wbuf[1] = 32'h7777_8888;
    txn(4'h3, 32'h0000_1018, 2, 4'h0, 8'h00);
    chk(!aborted, "R2", "io write claimed", aborted, 0);
    rd_check(4'h2, 32'h0000_1018, 2, 8'b0000_0010, "R2");

    // R6 aliased commands
    rdy_pat = 8'hFF;
    for (int i = 0; i < 3; i++) wbuf[i] = 32'h5A5A_0000 + i;
    txn(4'hF, 32'h8000_0024, 3, 4'h0, 8'h00);
    chk(!aborted, "R6", "mwi claimed", aborted, 0);
    rd_check(4'hC, 32'h8000_0024, 3, 8'h00, "R6");
    rd_check(4'hE, 32'h8000_0024, 3, 8'b0000_0100, "R6");

    // R7 unclaimed commands and window misses, no write reaches memory
    wbuf[0] = 32'hDEAD_DEAD;
    foreach (wbuf[i]) wbuf[i] = 32'hDEAD_DEAD;
    txn(4'h4, 32'h8000_0000, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "reserved 0100", aborted, 1);
    txn(4'h5, 32'h8000_0000, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "reserved 0101", aborted, 1);
    txn(4'h8, 32'h8000_0000, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "reserved 1000", aborted, 1);
    txn(4'h9, 32'h8000_0000, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "reserved 1001", aborted, 1);
    txn(4'hB, 32'h8000_0000, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "config write", aborted, 1);
    txn(4'hA, 32'h8000_0000, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "config read", aborted, 1);
    txn(4'h7, 32'h8000_0040, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "mem miss", aborted, 1);
    txn(4'h3, 32'h8000_0000, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "io at mem base", aborted, 1);
    txn(4'h7, 32'h0000_1000, 1, 4'h0, 8'h00);
    chk(aborted, "R7", "mem at io base", aborted, 1);
    full_compare("R7");

    // R8 R9 R10 long read with waits, checked per clock by the model
    rdy_pat = 8'b0111_0111;
    rd_check(4'h6, 32'h8000_0000, 8, 8'b1001_0000, "R8");
    repeat (3) @(posedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule